// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Unit

This unit gives a peripheral its place in a priority chain of interrupt sources wired through an enable-in / enable-out link. Internal sources raise request levels. The unit latches them into pending bits on the peripheral clock, ranks them in a fixed order and raises an active-low interrupt request. The request is raised only while some pending source outranks every source already being serviced.

The host acknowledges by pulling the acknowledge line low and then issuing one read strobe. Both lines are sampled on the rising clock edge. If the chain input is high when the read falling edge is seen during an acknowledge, the unit latches the winning source into its under-service bank. It then places that source's vector on an 8-bit output for the rest of the read and drops its request. A separate command input retires the highest-ranked under-service bit at the end of the handler. While the register pointer selects register 2 or 3, the pending bits hold, so a status read sees stable data.

Top module: `irq_chain_ack`

## Requirements
- R1: After reset, int_no is 1, ius_o is 0, vec_oe_o is 0, vec_o is 0, and ieo_o follows iei_i.
- R2: At each rising edge, every pending bit takes the value of src_req_i. The exception is an edge at which reg_ptr_i equals 2 or 3; there all pending bits keep their value.
- R3: Source index 0 has the highest rank. int_no is 0 exactly when some pending source i has no under-service bit at any index 0..i.
- R4: ieo_o is 1 only when iei_i is 1, no pending bit is set and ius_o is 0.
- R5: intack_ni is sampled at a rising edge. A read falling edge is an edge at which rd_ni is sampled low after being sampled high at the edge before. At a read falling edge where the acknowledge was already sampled low at an earlier edge, iei_i is 1 and int_no is 0, the under-service bit of the highest-ranked eligible source is set.
- R6: At that same edge vec_oe_o becomes 1. vec_o then carries the vector: bits 7..IDX_W are taken from VEC_BASE and the low IDX_W bits hold the source index. With the defaults this gives 0xA0 plus the index. vec_oe_o returns to 0 at the first edge at which rd_ni is sampled high, and vec_o is 0 whenever vec_oe_o is 0.
- R7: The edge that sets an under-service bit also drives int_no to 1, unless another pending source still outranks all under-service bits.
- R8: If iei_i is 0 at the read falling edge, no under-service bit is set and vec_oe_o stays 0.
- R9: Within one acknowledge, only the first read falling edge is acted on. Later read strobes set nothing until intack_ni has been sampled high.
- R10: A rising edge with rst_ius_i high clears only the highest-ranked set under-service bit.
- R11: A read strobe with no acknowledge sampled sets no under-service bit and drives no vector.
- R12: While a source is under service, a pending source of lower rank leaves int_no at 1, and a pending source of higher rank drives int_no to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | N_SRC | Request levels from internal sources |
| intack_ni | input | 1 | Interrupt acknowledge, active low |
| rd_ni | input | 1 | Read strobe, active low |
| iei_i | input | 1 | Chain enable in |
| reg_ptr_i | input | PTR_W | Current register pointer |
| rst_ius_i | input | 1 | Retire highest under-service bit |
| int_no | output | 1 | Interrupt request, active low |
| ieo_o | output | 1 | Chain enable out |
| ius_o | output | N_SRC | Under-service bits |
| vec_o | output | 8 | Vector during acknowledge read |
| vec_oe_o | output | 1 | Vector valid / drive enable |

## Verification
The bench holds the pointer on the status registers while the sources change. A design that does not freeze the pending bits would raise the request early. It acknowledges with the chain input low, and a design that ignores the chain would latch a source it does not own. It also issues a second read strobe inside one acknowledge while a higher source is pending. A design without the one-read guard would set a second under-service bit and drive a new vector. Nested priority and retirement of only the top under-service bit are tested with two bits set at once. Getting these wrong shows up as a wrong request level or as both bits cleared.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef logic [7:0] vec_t;
  localparam int unsigned FRZ_PTR_A = 2;
  localparam int unsigned FRZ_PTR_B = 3;
endpackage

// File: rtl/ack_sync.sv
module ack_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intack_ni,
  input  logic rd_ni,
  output logic ack_o,
  output logic rd_fall_o
);
  logic ack_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      rd_q  <= 1'b1;
    end else begin
      ack_q <= ~intack_ni;
      rd_q  <= rd_ni;
    end
  end

  assign ack_o     = ack_q;
  assign rd_fall_o = rd_q & ~rd_ni;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned PTR_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [PTR_W-1:0] reg_ptr_i,
  input  logic [N_SRC-1:0] ius_i,
  output logic [N_SRC-1:0] ip_o,
  output logic [N_SRC-1:0] grant_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             any_elig_o
);
  import irq_chain_pkg::*;

  logic [N_SRC-1:0] ip_q, blocked, elig, seen;
  logic frz;

  assign frz = (reg_ptr_i == PTR_W'(FRZ_PTR_A)) || (reg_ptr_i == PTR_W'(FRZ_PTR_B));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ip_q <= '0;
    else if (!frz) ip_q <= src_req_i;
  end

  // index 0 ranks highest; a source is blocked by any IUS at or above its rank
  assign blocked[0] = ius_i[0];
  assign seen[0]    = 1'b0;
  for (genvar i = 1; i < N_SRC; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | ius_i[i];
    assign seen[i]    = seen[i-1] | elig[i-1];
  end
  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i]    = ip_q[i] & ~blocked[i];
    assign grant_o[i] = elig[i] & ~seen[i];
  end

  always_comb begin
    grant_idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (elig[i]) grant_idx_o = IDX_W'(i);
  end

  assign ip_o       = ip_q;
  assign any_elig_o = |elig;
endmodule

// File: rtl/ius_bank.sv
module ius_bank #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             clr_hi_i,
  output logic [N_SRC-1:0] ius_o
);
  logic [N_SRC-1:0] ius_q, top;

  assign top = ius_q & (~ius_q + N_SRC'(1)); // lowest index set = highest rank

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ius_q <= '0;
    else         ius_q <= (ius_q & ~(clr_hi_i ? top : '0)) | set_i;
  end

  assign ius_o = ius_q;
endmodule

// File: rtl/irq_chain_ack.sv
module irq_chain_ack #(
  parameter int unsigned N_SRC    = 6,
  parameter int unsigned PTR_W    = 4,
  parameter logic [7:0]  VEC_BASE = 8'hA0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic             intack_ni,
  input  logic             rd_ni,
  input  logic             iei_i,
  input  logic [PTR_W-1:0] reg_ptr_i,
  input  logic             rst_ius_i,
  output logic             int_no,
  output logic             ieo_o,
  output logic [N_SRC-1:0] ius_o,
  output logic [7:0]       vec_o,
  output logic             vec_oe_o
);
  import irq_chain_pkg::*;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic             ack, rd_fall, any_elig, take, done_q, vec_oe_q;
  logic [N_SRC-1:0] ip, grant, ius;
  logic [IDX_W-1:0] gidx;
  vec_t             vec_q;

  ack_sync u_sync (
    .clk_i, .rst_ni, .intack_ni, .rd_ni,
    .ack_o(ack), .rd_fall_o(rd_fall)
  );

  irq_prio #(.N_SRC(N_SRC), .PTR_W(PTR_W)) u_prio (
    .clk_i, .rst_ni, .src_req_i, .reg_ptr_i,
    .ius_i(ius), .ip_o(ip), .grant_o(grant),
    .grant_idx_o(gidx), .any_elig_o(any_elig)
  );

  assign take = ack & rd_fall & ~done_q & iei_i & any_elig;

  ius_bank #(.N_SRC(N_SRC)) u_ius (
    .clk_i, .rst_ni,
    .set_i(take ? grant : '0), .clr_hi_i(rst_ius_i),
    .ius_o(ius)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      vec_oe_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      if (!ack)         done_q <= 1'b0;
      else if (rd_fall) done_q <= 1'b1; // one read per acknowledge
      if (take) begin
        vec_oe_q <= 1'b1;
        vec_q    <= {VEC_BASE[7:IDX_W], gidx};
      end else if (rd_ni) begin
        vec_oe_q <= 1'b0;
      end
    end
  end

  assign int_no   = ~any_elig;
  assign ieo_o    = iei_i & ~(|ip) & ~(|ius);
  assign ius_o    = ius;
  assign vec_oe_o = vec_oe_q;
  assign vec_o    = vec_oe_q ? vec_q : '0;
endmodule

// File: rtl/irq_chain_ack_chk.sv
module irq_chain_ack_chk #(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iei_i,
  input logic             rd_ni,
  input logic [PTR_W-1:0] reg_ptr_i,
  input logic             int_no,
  input logic             ieo_o,
  input logic [N_SRC-1:0] ius_o,
  input logic             vec_oe_o,
  input logic [7:0]       vec_o
);
  logic frz;
  assign frz = (reg_ptr_i == PTR_W'(2)) || (reg_ptr_i == PTR_W'(3));

  a_r2_freeze_holds_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frz) && $stable(ius_o)) |-> $stable(int_no));

  a_r4_ieo_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ieo_o |-> (ius_o == '0));

  a_r5_ius_set_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ius_o & ~$past(ius_o)) != '0) |-> ($past(!rd_ni) && $past(iei_i)));

  a_r9_one_ius_per_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ius_o & ~$past(ius_o)));

  a_r6_vec_with_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_oe_o) |-> $onehot(ius_o & ~$past(ius_o)));

  a_r6_vec_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> (vec_o == 8'h00));
endmodule

bind irq_chain_ack irq_chain_ack_chk #(.N_SRC(N_SRC), .PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .iei_i(iei_i), .rd_ni(rd_ni),
  .reg_ptr_i(reg_ptr_i), .int_no(int_no), .ieo_o(ieo_o), .ius_o(ius_o),
  .vec_oe_o(vec_oe_o), .vec_o(vec_o)
);

// File: tb/sim_irq_chain_ack.sv
`timescale 1ns/1ps
module sim_irq_chain_ack;
  localparam int N = 6;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] src_req_i = '0;
  logic         intack_ni = 1'b1, rd_ni = 1'b1, iei_i = 1'b1, rst_ius_i = 1'b0;
  logic [3:0]   reg_ptr_i = '0;
  logic         int_no, ieo_o, vec_oe_o;
  logic [N-1:0] ius_o;
  logic [7:0]   vec_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_chain_ack u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      #5;
    end
  endtask

  // ack sampled at first edge, read fall seen at second
  task automatic ack_read();
    intack_ni = 1'b0; step();
    rd_ni = 1'b0;     step();
  endtask

  task automatic end_ack();
    rd_ni = 1'b1;     step();
    intack_ni = 1'b1; step(2);
  endtask

  task automatic retire_all();
    rst_ius_i = 1'b1; step(N); rst_ius_i = 1'b0;
    src_req_i = '0;   step();
  endtask

  task automatic t_reset();
    chk("R1 int_no", int_no, 1);
    chk("R1 ius", ius_o, 0);
    chk("R1 vec_oe", vec_oe_o, 0);
    chk("R1 vec", vec_o, 0);
    chk("R1 ieo", ieo_o, 1);
  endtask

  task automatic t_freeze();
    reg_ptr_i = 4'd2; src_req_i = 6'b000010; step(2);
    chk("R2 frozen ptr2", int_no, 1);
    reg_ptr_i = 4'd3; step();
    chk("R2 frozen ptr3", int_no, 1);
    reg_ptr_i = 4'd0; step();
    chk("R2 update", int_no, 0);
    chk("R4 ieo low pending", ieo_o, 0);
    src_req_i = '0; step();
    chk("R3 clear", int_no, 1);
  endtask

  task automatic t_basic_ack();
    src_req_i = 6'b010100; step();
    chk("R3 req", int_no, 0);
    ack_read();
    chk("R5 ius set", ius_o, 6'b000100);
    chk("R6 vec", vec_o, 8'hA2);
    chk("R6 vec_oe", vec_oe_o, 1);
    chk("R7 int off", int_no, 1);
    chk("R4 ieo low ius", ieo_o, 0);
    rd_ni = 1'b1; step();
    chk("R6 vec_oe drop", vec_oe_o, 0);
    chk("R6 vec zero", vec_o, 0);
    intack_ni = 1'b1; step(2);
    retire_all();
    chk("R10 all retired", ius_o, 0);
  endtask

  task automatic t_chain_low();
    src_req_i = 6'b001000; step();
    iei_i = 1'b0;
    chk("R4 ieo follows iei", ieo_o, 0);
    ack_read();
    chk("R8 no ius", ius_o, 0);
    chk("R8 no vec", vec_oe_o, 0);
    end_ack();
    iei_i = 1'b1;
    src_req_i = '0; step();
  endtask

  task automatic t_double_read();
    src_req_i = 6'b100000; step();
    ack_read();
    chk("R5 ius5", ius_o, 6'b100000);
    chk("R6 vec5", vec_o, 8'hA5);
    rd_ni = 1'b1; src_req_i = 6'b100001; step();
    rd_ni = 1'b0; step();
    chk("R9 second read ignored", ius_o, 6'b100000);
    chk("R9 no vec", vec_oe_o, 0);
    chk("R12 higher asserts", int_no, 0);
    end_ack();
    ack_read();
    chk("R9 new ack ok", ius_o, 6'b100001);
    chk("R6 vec0", vec_o, 8'hA0);
    end_ack();
    rst_ius_i = 1'b1; step(); rst_ius_i = 1'b0;
    chk("R10 top retired", ius_o, 6'b100000);
    retire_all();
  endtask

  task automatic t_nesting();
    src_req_i = 6'b001000; step();
    ack_read(); end_ack();
    chk("R5 ius3", ius_o, 6'b001000);
    src_req_i = 6'b011000; step();
    chk("R12 lower masked", int_no, 1);
    src_req_i = 6'b011010; step();
    chk("R12 higher wins", int_no, 0);
    ack_read(); end_ack();
    chk("R5 ius1+3", ius_o, 6'b001010);
    rst_ius_i = 1'b1; step(); rst_ius_i = 1'b0;
    chk("R10 only top", ius_o, 6'b001000);
    retire_all();
  endtask

  task automatic t_read_no_ack();
    src_req_i = 6'b000001; step();
    rd_ni = 1'b0; step();
    chk("R11 no ius", ius_o, 0);
    chk("R11 no vec", vec_oe_o, 0);
    rd_ni = 1'b1; src_req_i = '0; step();
    chk("R4 ieo idle", ieo_o, 1);
  endtask

  initial begin
    #25; rst_ni = 1'b1; #5;
    t_reset();
    t_freeze();
    t_basic_ack();
    t_chain_low();
    t_double_read();
    t_nesting();
    t_read_no_ack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule